// File: doc/BRIEF.md
# Cascadable Nibble-Loading Column Register

This block assembles one display line of column bits, four bits per transfer, for a column driver stage. It runs from a system clock and watches two slow strobes from the display controller: a data strobe, each falling edge of which offers one 4-bit nibble, and a line strobe, whose falling edge starts a new line. The strobes and the data are brought into the clock domain through a two-stage synchroniser. A falling edge is found by comparing each strobe with its previous synchronised sample.

Several identical units can be chained to span a wide row. Each unit has an active-low enable input and an active-low carry output. The carry of one unit drives the enable of the next, so the first unit takes its share of nibbles and then hands loading on to the next unit. A direction input chooses which end of the line fills first. When the line fills from the far end, each nibble is also bit-mirrored, so the column order is exactly reversed. A disabled or full unit ignores the data strobe and does not change its register.

Top module: `col_line_loader`

## Requirements
- R1: During reset (rst_ni low) and right after it, line_o is all zeros, full_o is 0 and carry_no is 1.
- R2: A data-strobe falling edge that is seen while en_ni is low and the unit is not full writes exactly one nibble, and the fill position advances by one.
- R3: After 20 nibbles (NUM_COLS/4 with the default of 80 columns) the fill position saturates. Further data-strobe edges leave line_o unchanged.
- R4: full_o is 1 and carry_no is 0 exactly when the unit holds a complete set of nibbles since the last reset or line strobe.
- R5: With fwd_i high, nibble number k (counting from 0) lands so that bit j of nib_i drives line_o[4k+j].
- R6: With fwd_i low, nibble number k lands so that bit j of nib_i drives line_o[NUM_COLS-1-4k-j]. This reverses both the slot order and the bit order.
- R7: While en_ni is high, data-strobe edges are ignored: line_o and the fill position do not change.
- R8: A line-strobe falling edge resets the fill position to 0, drives carry_no high and full_o low, and leaves line_o unchanged.
- R9: When the line strobe and the data strobe fall in the same clock sample, the line strobe takes priority. No nibble is written, and the next nibble lands in slot 0.
- R10: If a strobe falls before rising edge E1, its effect shows on the outputs after rising edge E3, which is the third rising clock edge counting E1 as the first. The data that is written is the nib_i, fwd_i and en_ni level sampled together with the strobe's first low sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Unit enable, active low (carry of the previous unit) |
| dstb_i | input | 1 | Data strobe; a falling edge offers one nibble |
| lstb_i | input | 1 | Line strobe; a falling edge starts a new line |
| fwd_i | input | 1 | Fill direction: 1 fills from column 0 upward, 0 fills from the top column down with nibbles mirrored |
| nib_i | input | 4 | Nibble data |
| line_o | output | NUM_COLS | Assembled line |
| full_o | output | 1 | All nibbles loaded |
| carry_no | output | 1 | Active-low carry that enables the next unit |

## Verification
A behavioural reference model with sample queues is compared against the design on every cycle. Directed phases also check known patterns. An incrementing nibble pattern loaded forward, and a scrambled pattern loaded in reverse, tell the slot order apart from the in-nibble bit mirroring. Strobes sent while the unit is disabled, and strobes sent after the unit is full, show that the register is left alone in both cases. A single strobe is watched cycle by cycle to pin down the latency. A line strobe that coincides with a data strobe, followed by one more nibble, shows the clear winning and filling restarting at slot 0.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;

  function automatic nib_t mirror_nib(nib_t v);
    nib_t r;
    for (int i = 0; i < NIB_W; i++) r[i] = v[NIB_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
  import col_loader_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dstb_i,
  input  logic lstb_i,
  input  logic en_ni,
  input  logic fwd_i,
  input  nib_t nib_i,
  output logic dstb_fall_o,
  output logic lstb_fall_o,
  output logic en_no,
  output logic fwd_o,
  output nib_t nib_o
);
  localparam int BW = 4 + NIB_W;
  // bundle order: {dstb, lstb, en_n, fwd, nib}
  localparam logic [BW-1:0] IDLE = {1'b1, 1'b1, 1'b1, 1'b1, {NIB_W{1'b0}}};

  logic [BW-1:0] s1_q, s2_q;
  logic [1:0]    s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
      s3_q <= 2'b11;
    end else begin
      s1_q <= {dstb_i, lstb_i, en_ni, fwd_i, nib_i};
      s2_q <= s1_q;
      s3_q <= s2_q[BW-1 -: 2];
    end
  end

  assign dstb_fall_o = s3_q[1] & ~s2_q[BW-1];
  assign lstb_fall_o = s3_q[0] & ~s2_q[BW-2];
  assign en_no       = s2_q[BW-3];
  assign fwd_o       = s2_q[BW-4];
  assign nib_o       = s2_q[NIB_W-1:0];
endmodule

// File: rtl/nib_counter.sv
module nib_counter #(
  parameter int NUM_NIBS = 20,
  localparam int CNT_W   = $clog2(NUM_NIBS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (step_i && !full_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign full_o = (cnt_q == CNT_W'(NUM_NIBS));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/line_store.sv
module line_store
  import col_loader_pkg::*;
#(
  parameter int NUM_COLS = 80,
  localparam int NUM_NIBS = NUM_COLS / NIB_W,
  localparam int CNT_W    = $clog2(NUM_NIBS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                fwd_i,
  input  logic [CNT_W-1:0]    slot_i,
  input  nib_t                nib_i,
  output logic [NUM_COLS-1:0] line_o
);
  logic [CNT_W-1:0] tgt;
  nib_t             wdata;

  // reverse fill: far slot first, bits mirrored
  assign tgt   = fwd_i ? slot_i : CNT_W'(NUM_NIBS - 1) - slot_i;
  assign wdata = fwd_i ? nib_i : mirror_nib(nib_i);

  for (genvar g = 0; g < NUM_NIBS; g++) begin : g_slot
    nib_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         slot_q <= '0;
      else if (wr_i && tgt == CNT_W'(g))   slot_q <= wdata;
    end
    assign line_o[g*NIB_W +: NIB_W] = slot_q;
  end
endmodule

// File: rtl/col_line_loader.sv
module col_line_loader
  import col_loader_pkg::*;
#(
  parameter int NUM_COLS = 80
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_ni,
  input  logic                dstb_i,
  input  logic                lstb_i,
  input  logic                fwd_i,
  input  logic [3:0]          nib_i,
  output logic [NUM_COLS-1:0] line_o,
  output logic                full_o,
  output logic                carry_no
);
  localparam int NUM_NIBS = NUM_COLS / NIB_W;
  localparam int CNT_W    = $clog2(NUM_NIBS + 1);

  logic             dstb_fall, lstb_fall, en_s, fwd_s, full, nib_wr;
  nib_t             nib_s;
  logic [CNT_W-1:0] nib_cnt;

  strobe_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dstb_i     (dstb_i),
    .lstb_i     (lstb_i),
    .en_ni      (en_ni),
    .fwd_i      (fwd_i),
    .nib_i      (nib_i),
    .dstb_fall_o(dstb_fall),
    .lstb_fall_o(lstb_fall),
    .en_no      (en_s),
    .fwd_o      (fwd_s),
    .nib_o      (nib_s)
  );

  // line clear wins over a coincident data strobe
  assign nib_wr = dstb_fall & ~en_s & ~full & ~lstb_fall;

  nib_counter #(.NUM_NIBS(NUM_NIBS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (lstb_fall),
    .step_i(nib_wr),
    .cnt_o (nib_cnt),
    .full_o(full)
  );

  line_store #(.NUM_COLS(NUM_COLS)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (nib_wr),
    .fwd_i (fwd_s),
    .slot_i(nib_cnt),
    .nib_i (nib_s),
    .line_o(line_o)
  );

  assign full_o   = full;
  assign carry_no = ~full;
endmodule

// File: rtl/col_loader_chk.sv
module col_loader_chk #(
  parameter int NUM_COLS = 80,
  localparam int NUM_NIBS = NUM_COLS / 4,
  localparam int CNT_W    = $clog2(NUM_NIBS + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_COLS-1:0] line_o,
  input logic                full_o,
  input logic                carry_no,
  input logic [CNT_W-1:0]    nib_cnt,
  input logic                nib_wr,
  input logic                lstb_fall,
  input logic                dstb_fall
);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_cnt <= CNT_W'(NUM_NIBS));

  a_r3_full_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> $stable(line_o));

  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_wr |=> nib_cnt == $past(nib_cnt) + CNT_W'(1));

  a_r7_no_strobe_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dstb_fall && !lstb_fall) |=> ($stable(line_o) && $stable(nib_cnt)));

  a_r8_line_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lstb_fall |=> (nib_cnt == '0 && carry_no && $stable(line_o)));

  a_r4_carry_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(carry_no) |-> $rose(full_o));

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni -> (line_o == '0 && carry_no && !full_o)));
endmodule

bind col_line_loader col_loader_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .line_o   (line_o),
  .full_o   (full_o),
  .carry_no (carry_no),
  .nib_cnt  (nib_cnt),
  .nib_wr   (nib_wr),
  .lstb_fall(lstb_fall),
  .dstb_fall(dstb_fall)
);

// File: tb/col_line_loader_bench.sv
module col_line_loader_bench;
  localparam int NC = 80;
  localparam int NN = NC / 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_ni = 1'b1, dstb_i = 1'b1, lstb_i = 1'b1, fwd_i = 1'b1;
  logic [3:0]    nib_i = 4'h0;
  logic [NC-1:0] line_o;
  logic          full_o, carry_no;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  col_line_loader #(.NUM_COLS(NC)) u_col_line_loader (
    .clk_i, .rst_ni, .en_ni, .dstb_i, .lstb_i, .fwd_i, .nib_i,
    .line_o, .full_o, .carry_no
  );

  // reference model: queues of the last three input samples
  logic          q_d[$], q_l[$], q_e[$], q_f[$];
  logic [3:0]    q_n[$];
  logic [NC-1:0] m_line = '0;
  int            m_cnt = 0;

  task automatic model_reset();
    q_d = '{1'b1, 1'b1, 1'b1}; q_l = '{1'b1, 1'b1, 1'b1};
    q_e = '{1'b1, 1'b1, 1'b1}; q_f = '{1'b1, 1'b1, 1'b1};
    q_n = '{4'h0, 4'h0, 4'h0};
    m_line = '0; m_cnt = 0;
  endtask

  initial model_reset();

  always @(posedge clk_i) begin
    if (!rst_ni) model_reset();
    else begin
      // q[0] oldest (three edges back), q[1] two edges back
      if (q_l[0] && !q_l[1]) m_cnt = 0;
      else if (q_d[0] && !q_d[1] && !q_e[1] && m_cnt < NN) begin
        for (int j = 0; j < 4; j++) begin
          if (q_f[1]) m_line[4*m_cnt + j] = q_n[1][j];
          else        m_line[NC-1-4*m_cnt-j] = q_n[1][j];
        end
        m_cnt++;
      end
      void'(q_d.pop_front()); void'(q_l.pop_front()); void'(q_e.pop_front());
      void'(q_f.pop_front()); void'(q_n.pop_front());
      q_d.push_back(dstb_i); q_l.push_back(lstb_i); q_e.push_back(en_ni);
      q_f.push_back(fwd_i);  q_n.push_back(nib_i);
    end
  end

  task automatic chk(bit ok, string tag, logic [NC-1:0] act, logic [NC-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R2 R4 R10)
  always @(negedge clk_i) begin
    if (!done) begin
      chk(line_o === m_line, "R2 model line", line_o, m_line);
      chk(full_o === (m_cnt == NN) && carry_no === (m_cnt != NN), "R4 model full/carry",
          NC'({full_o, carry_no}), NC'({m_cnt == NN, m_cnt != NN}));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send(logic [3:0] v);
    @(negedge clk_i); nib_i = v;
    cyc(1); dstb_i = 1'b0;
    cyc(3); dstb_i = 1'b1;
    cyc(3);
  endtask

  task automatic line_pulse();
    @(negedge clk_i); lstb_i = 1'b0;
    cyc(3); lstb_i = 1'b1;
    cyc(3);
  endtask

  logic [3:0]    pat[NN];
  logic [NC-1:0] exp_line, snap;

  initial begin
    cyc(2);
    chk(line_o == '0 && !full_o && carry_no, "R1 reset", line_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc(2);
    chk(line_o == '0 && !full_o && carry_no, "R1 after reset", line_o, '0);

    // R10 latency on first nibble
    en_ni = 1'b0; fwd_i = 1'b1;
    @(negedge clk_i); nib_i = 4'h9;
    cyc(1); dstb_i = 1'b0;
    cyc(2);
    chk(line_o == '0, "R10 before third edge", line_o, '0);
    cyc(1);
    chk(line_o == NC'(4'h9), "R10 at third edge", line_o, NC'(4'h9));
    cyc(1); dstb_i = 1'b1; cyc(3);

    // R5 forward fill
    pat[0] = 4'h9;
    for (int k = 1; k < NN; k++) begin pat[k] = 4'(k); send(pat[k]); end
    exp_line = '0;
    for (int k = 0; k < NN; k++) for (int j = 0; j < 4; j++) exp_line[4*k+j] = pat[k][j];
    chk(line_o == exp_line, "R5 forward map", line_o, exp_line);
    chk(full_o && !carry_no, "R4 full after 20", NC'({full_o, carry_no}), NC'(2'b10));

    // R3 saturation
    send(4'hF); send(4'h0);
    chk(line_o == exp_line, "R3 saturated", line_o, exp_line);

    // R8 line clear
    line_pulse();
    chk(!full_o && carry_no, "R8 carry high", NC'({full_o, carry_no}), NC'(2'b01));
    chk(line_o == exp_line, "R8 line kept", line_o, exp_line);

    // R7 disabled
    en_ni = 1'b1;
    send(4'h5); send(4'hA); send(4'h3);
    chk(line_o == exp_line && carry_no, "R7 disabled ignored", line_o, exp_line);

    // R6 reverse fill
    en_ni = 1'b0; fwd_i = 1'b0;
    for (int k = 0; k < NN; k++) begin pat[k] = 4'((k * 7 + 3) % 16); send(pat[k]); end
    exp_line = '0;
    for (int k = 0; k < NN; k++) for (int j = 0; j < 4; j++) exp_line[NC-1-4*k-j] = pat[k][j];
    chk(line_o == exp_line, "R6 reverse map", line_o, exp_line);
    chk(full_o && !carry_no, "R4 full reverse", NC'({full_o, carry_no}), NC'(2'b10));

    // R9 coincident strobes
    line_pulse();
    fwd_i = 1'b1;
    for (int k = 0; k < 5; k++) send(4'hC);
    snap = line_o;
    @(negedge clk_i); nib_i = 4'hE;
    cyc(1); dstb_i = 1'b0; lstb_i = 1'b0;
    cyc(3); dstb_i = 1'b1; lstb_i = 1'b1;
    cyc(3);
    chk(line_o == snap, "R9 no write on clash", line_o, snap);
    send(4'h6);
    exp_line = snap; exp_line[3:0] = 4'h6;
    chk(line_o == exp_line, "R9 restart at slot 0", line_o, exp_line);

    cyc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule